// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an on-chip requester to an external asynchronous static RAM of 131,072 bytes. The requester offers one access at a time through a valid/ready handshake: a 17-bit address, a write flag and 8 bits of write data. Reads come back on a data port together with a one-cycle valid pulse.

On the memory side the controller drives active-low chip select, read enable and write strobe, a registered address bus and a split data bus. The split data bus has separate outgoing data, incoming data and a driver-enable signal. Every phase of the strobe sequence lasts a whole number of system clock cycles, and each count is a parameter. The integrator derives each count from the memory's nanosecond limits and the clock period, rounding up. Writes end on the rising edge of the write strobe while chip select is still low. When a write directly follows a read, the controller inserts idle cycles so that the memory's output drivers have floated before its own driver turns on.

When no access is pending, chip select stays high and the memory sits in standby. All cycle counts must be at least 1.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, chip select, read enable and write strobe are high, the data driver is off, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: With no request pending, chip select stays high and the data driver stays off for as long as the requester stays idle.
- R3: A read holds chip select and read enable low and the write strobe high for RD_CYC cycles. The data bus is sampled at the last edge of that window and returned on `rsp_rdata_o` with `rsp_valid_o` high for exactly one cycle. The pulse becomes visible RD_CYC cycles after the accepting edge.
- R4: A write drives data with chip select low and the write strobe high for SU_CYC cycles. It then holds the write strobe low for exactly WP_CYC cycles, then keeps the strobe high with chip select low and data driven for HD_CYC cycles. The write strobe is low only while chip select is low.
- R5: The data driver is never on while read enable is low, so the controller and the memory never drive the bus together.
- R6: A write accepted in the first idle cycle after a read first spends TA_CYC cycles with chip select high and the driver off. A write that follows a write or an idle cycle starts its setup phase at once.
- R7: `req_ready_o` is low from the accepting edge until the sequence ends. Reads stay busy for RD_CYC cycles. Writes stay busy for SU_CYC+WP_CYC+HD_CYC cycles, plus TA_CYC when R6 applies.
- R8: Address and write data are captured at acceptance and held steady for the whole access. Changes on the request inputs while busy have no effect on the access or on the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request taken on this edge |
| req_addr_i | input | 17 | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | 8 | Read data |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_oe_no | output | 1 | Memory read enable, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_addr_o | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Driver enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from memory |

## Verification
A sequencer stuck in or skipping a phase shows up at the pins at once. A wrong write-strobe width or setup count is visible on the rising strobe edge. A missing turnaround shows up as a busy time one cycle short on the very next write after a read. A datapath register loaded at the wrong time corrupts the stored word, and this only appears on the later read-back of that address, so every write in the bench is read back. Bus contention is flagged in the same cycle by the memory model.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_RD, ST_WSU, ST_WPL, ST_WHD
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STB_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  function automatic strobe_t strobe_of(state_e s);
    strobe_t r;
    r = STB_OFF;
    case (s)
      ST_RD:  begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
      ST_WSU: begin r.ce_n = 1'b0; r.dq_oe = 1'b1; end
      ST_WPL: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.dq_oe = 1'b1; end
      ST_WHD: begin r.ce_n = 1'b0; r.dq_oe = 1'b1; end
      default: r = STB_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/100ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 1,
  parameter int SU_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int HD_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    req_we_i,
  output logic    accept_o,
  output logic    rd_done_o,
  output logic    ready_o,
  output strobe_t strobe_o
);
  localparam int MAX_A = (RD_CYC > SU_CYC) ? RD_CYC : SU_CYC;
  localparam int MAX_B = (WP_CYC > HD_CYC) ? WP_CYC : HD_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > TA_CYC) ? MAX_C : TA_CYC;
  localparam int CNT_W = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] LD_RD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SU = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HD = CNT_W'(HD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TA = CNT_W'(TA_CYC - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_rd_q, last_rd_d;
  logic             cnt_end;
  strobe_t          strobe_q;

  assign cnt_end = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_end ? cnt_q : cnt_q - 1'b1;
    last_rd_d = last_rd_q;
    accept_o  = 1'b0;
    rd_done_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o  = 1'b1;
          last_rd_d = 1'b0;
          if (!req_we_i) begin
            state_d = ST_RD;   cnt_d = LD_RD;
          end else if (last_rd_q) begin
            state_d = ST_TURN; cnt_d = LD_TA;
          end else begin
            state_d = ST_WSU;  cnt_d = LD_SU;
          end
        end else begin
          last_rd_d = 1'b0;  // an idle cycle already separates the bus owners
        end
      end
      ST_TURN: if (cnt_end) begin state_d = ST_WSU; cnt_d = LD_SU; end
      ST_WSU:  if (cnt_end) begin state_d = ST_WPL; cnt_d = LD_WP; end
      ST_WPL:  if (cnt_end) begin state_d = ST_WHD; cnt_d = LD_HD; end
      ST_WHD:  if (cnt_end) state_d = ST_IDLE;
      ST_RD: if (cnt_end) begin
        state_d   = ST_IDLE;
        rd_done_o = 1'b1;
        last_rd_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
      strobe_q  <= STB_OFF;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      last_rd_q <= last_rd_d;
      strobe_q  <= strobe_of(state_d);
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign strobe_o = strobe_q;

endmodule

// File: rtl/sram_ctrl_dp.sv
`timescale 1ns/100ps
module sram_ctrl_dp #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          rd_done_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rsp_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o      <= '0;
      wdata_o     <= '0;
      rdata_o     <= '0;
      rsp_valid_o <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (rd_done_i) rdata_o <= mem_dq_i;
      rsp_valid_o <= rd_done_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/100ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int RD_CYC = 1,
  parameter int SU_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int HD_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  logic    accept, rd_done;
  strobe_t stb;

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .WP_CYC(WP_CYC),
    .HD_CYC(HD_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .accept_o    (accept),
    .rd_done_o   (rd_done),
    .ready_o     (req_ready_o),
    .strobe_o    (stb)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .rd_done_i   (rd_done),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_dq_o),
    .rdata_o     (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  assign mem_ce_no   = stb.ce_n;
  assign mem_oe_no   = stb.oe_n;
  assign mem_we_no   = stb.we_n;
  assign mem_dq_oe_o = stb.dq_oe;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/100ps
module sram_ctrl_chk #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int WP_CYC = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_ce_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_dq_o
);
  logic [15:0] we_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_lo_q <= '0;
    else if (!mem_we_no) we_lo_q <= we_lo_q + 16'd1;
    else                 we_lo_q <= '0;
  end

  AST_BUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no)); // R5
  AST_WE_IN_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no); // R4
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_lo_q == 16'(WP_CYC))); // R4
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R3
  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |=> !mem_dq_oe_o); // R6
  AST_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> !mem_dq_oe_o); // R2
  AST_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o)); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o)); // R8

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW), .WP_CYC(WP_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_ce_no   (mem_ce_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_o    (mem_dq_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/100ps
module sram_ctrl_tb;
  localparam int AW = 17, DW = 8;
  localparam int RD = 1, SU = 1, WP = 1, HD = 1, TA = 1;
  localparam int NV = 11;
  // {we, addr, wdata, expected read}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'h11, 8'h00},
    {1'b1, 17'h1FFFF, 8'hA5, 8'h00},
    {1'b1, 17'h0ABCD, 8'h3C, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'h11},
    {1'b0, 17'h1FFFF, 8'h00, 8'hA5},
    {1'b1, 17'h00000, 8'h77, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'h77},
    {1'b0, 17'h0ABCD, 8'h00, 8'h3C},
    {1'b0, 17'h12345, 8'h00, 8'h00},
    {1'b1, 17'h12345, 8'hE1, 8'h00},
    {1'b0, 17'h12345, 8'h00, 8'hE1}
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_dq_o;
  logic [DW-1:0] m_dq_i = '0;

  int checks = 0, failures = 0;
  bit prev_rd = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD), .SU_CYC(SU), .WP_CYC(WP),
              .HD_CYC(HD), .TA_CYC(TA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_addr_o(m_addr), .mem_dq_o(m_dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(m_dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory: stores on rising write strobe, flags overlap and short windows
  logic [DW-1:0] mdl [logic [AW-1:0]];
  int  wl_cnt = 0, su_cnt = 0, hd_cnt = 0, contention = 0;
  bit  prev_we_lo = 1'b0, prev_mdrv = 1'b0, in_hold = 1'b0;

  always @(negedge clk) begin
    bit mdrv;
    if (rst_n) begin
      mdrv = !ce_n && !oe_n && we_n;
      if (mdrv && dq_oe) contention++;
      if (dq_oe && prev_mdrv) contention++;
      if (!we_n) wl_cnt++;
      if (we_n && prev_we_lo) begin
        mdl[m_addr] = m_dq_o;
        chk(wl_cnt == WP, "R4 strobe low width", wl_cnt, WP);
        chk(su_cnt == SU, "R4 setup before strobe", su_cnt, SU);
        wl_cnt = 0; su_cnt = 0; hd_cnt = 0; in_hold = 1'b1;
      end
      if (!ce_n && we_n && dq_oe && !in_hold) su_cnt++;
      if (in_hold && !ce_n) hd_cnt++;
      if (in_hold && ce_n) begin
        chk(hd_cnt == HD, "R4 hold after strobe", hd_cnt, HD);
        in_hold = 1'b0;
      end
      if (ce_n) su_cnt = 0;
      m_dq_i <= mdrv ? (mdl.exists(m_addr) ? mdl[m_addr] : 8'h00) : 8'h00;
      prev_mdrv = mdrv;
      prev_we_lo = !we_n;
    end
  end

  // issue at a negedge, return at the negedge where ready is back
  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] exp, input string tag);
    int busy, exp_busy;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
    exp_busy = we ? ((prev_rd ? TA : 0) + SU + WP + HD) : RD;
    chk(busy == exp_busy, we ? (prev_rd ? "R6 busy write after read" : "R7 busy write") : "R7 busy read",
        busy, exp_busy);
    if (!we) begin
      chk(rsp_valid == 1'b1, "R3 rsp_valid at return", rsp_valid, 1);
      chk(rsp_rdata == exp, {"R3 read data ", tag}, rsp_rdata, exp);
    end
    prev_rd = !we;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    if (n > 0) prev_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 strobes high in reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(!dq_oe, "R1 driver off in reset", dq_oe, 0);
    chk(!rsp_valid, "R1 rsp_valid low in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(ce_n && !dq_oe, "R1 idle after reset", {ce_n, dq_oe}, 2'b10);

    // R2: standby while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ce_n && !dq_oe, "R2 standby idle", {ce_n, dq_oe}, 2'b10);
    end
    prev_rd = 1'b0;

    for (int v = 0; v < NV; v++)
      do_op(VEC[v][33], VEC[v][32:16], VEC[v][15:8], VEC[v][7:0], $sformatf("vec%0d", v));

    // R3: read strobe levels and single-cycle valid
    idle(2);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 17'h0ABCD;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ce_n && !oe_n && we_n && !dq_oe, "R3 read strobes", {ce_n, oe_n, we_n, dq_oe}, 4'b0010);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 8'h3C, "R3 read return", rsp_rdata, 8'h3C);
    @(negedge clk);
    chk(!rsp_valid, "R3 valid one cycle", rsp_valid, 0);

    // R4/R8: write phases, request inputs changed while busy
    idle(2);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00555; req_wdata = 8'h96;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 17'h00666; req_wdata = 8'h5B; req_we = 1'b0;
    chk(!ce_n && we_n && oe_n && dq_oe, "R4 setup phase", {ce_n, we_n, oe_n, dq_oe}, 4'b0111);
    @(negedge clk);
    req_valid = 1'b1;  // offered while busy: must wait
    chk(!ce_n && !we_n && dq_oe && m_addr == 17'h00555, "R8 pulse phase addr held", m_addr, 17'h00555);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ce_n && we_n && dq_oe && m_dq_o == 8'h96, "R8 hold phase data held", m_dq_o, 8'h96);
    @(negedge clk);
    chk(ce_n && !dq_oe, "R2 back to standby after write", {ce_n, dq_oe}, 2'b10);
    prev_rd = 1'b0;
    do_op(1'b0, 17'h00555, 8'h00, 8'h96, "R8 stored word");
    idle(1);
    do_op(1'b0, 17'h00666, 8'h00, 8'h00, "R8 untouched word");

    // R6: read then write with one idle cycle between: no turnaround
    idle(1);
    do_op(1'b1, 17'h00777, 8'hC3, 8'h00, "R6 write after idle");
    do_op(1'b0, 17'h00777, 8'h00, 8'hC3, "R6 readback");

    idle(2);
    chk(contention == 0, "R5 bus overlap events", contention, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule